// File: doc/BRIEF.md
# Programmable Down-Counter with Latched Underflow Interrupt

This block is a 16-bit down-counter that steps once on each pulse of a chosen rate strobe. Two single-cycle enable pulses come in from outside: a slow one, nominally 2 kHz, and a fast one, nominally 512 kHz. A control bit picks which of them drives the counter. Software reaches the block through a small register port. It can load a start value, read the live count, set the rate and mode bits, and acknowledge the interrupt.

When the counter is at zero and the selected strobe arrives, the block records an underflow. What it loads next depends on the mode bit:
- In wrap mode it continues from all ones.
- In reload mode it restarts from the last value software wrote.

Each underflow sets a status bit. That bit stays set until software writes to the acknowledge address. The interrupt pin shows the status bit gated by an enable input.

A control state machine has two states:
- **ST_ARMED** is entered on every write to the value register (transition *LOAD*). It absorbs the first selected strobe without counting (transition *FIRST_STROBE*, leading to ST_COUNT).
- **ST_COUNT** decrements on each selected strobe (transition *STEP*) and handles zero (transition *UNDERFLOW*).

A write in either state returns the machine to ST_ARMED. Because of this, a freshly written value is first decremented on the second strobe after the write.

Top module: `cdt_timer`

## Requirements
- R1: After reset the count reads 0xFFFF, the rate bit and mode bit read 0, the machine is in ST_COUNT and irq_o is 0.
- R2: A write to the value address (bus_addr 0) loads the count. The first selected strobe after that write leaves the count unchanged, and the second selected strobe decrements it.
- R3: In ST_COUNT each selected strobe decrements a non-zero count by one. Control bit 0 selects the strobe: 0 selects slow_tick and 1 selects fast_tick. The strobe that is not selected has no effect on the count.
- R4: When control bit 1 is 0 (wrap mode), a selected strobe at count 0 makes the count 0xFFFF.
- R5: When control bit 1 is 1 (reload mode), a selected strobe at count 0 makes the count equal to the last value written to the value address.
- R6: Every underflow sets a status bit whatever the state of irq_en. irq_o is high only when that status bit is set and irq_en is high.
- R7: Any write to address 2 clears the status bit. If an underflow occurs in the same cycle as that write, the status bit stays set.
- R8: A value write may happen at any time. A write coinciding with a selected strobe loads the written value without decrementing it and restarts the two-strobe wait.
- R9: Reads are combinational and behave as follows:
  - Address 0 returns the live count.
  - Address 1 returns the rate bit in bit 0 and the mode bit in bit 1, with zeros elsewhere.
  - Addresses 2 and 3 return 0.
  - A write to address 1 stores the rate and mode bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | Slow rate strobe, one cycle per period |
| fast_tick | input | 1 | Fast rate strobe, one cycle per period |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq_en | input | 1 | Interrupt enable |
| irq_o | output | 1 | Gated underflow interrupt |

## Verification
The bench targets four corner cases:
- **Swallowed first strobe after a write.** A design that counts at once shows the loaded value minus one after a single strobe.
- **The step from zero.** A design that mixes up the modes returns 0xFFFF in reload mode, or the reload value in wrap mode.
- **An acknowledge arriving in the same cycle as a new underflow.** A design that gives the clear priority drops that interrupt.
- **A value write landing on a strobe.** A design that lets the strobe through reads one below the written value, or fails to restart the two-strobe wait.

Strobes that are not selected are also sent to catch a wrong rate multiplexer.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_COUNT = 1'b1
    } cdt_state_e;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_VALUE = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd1;
    localparam logic [ADDR_W-1:0] A_ACK   = 2'd2;

    localparam int CTRL_RATE_BIT = 0;
    localparam int CTRL_MODE_BIT = 1;

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  count_i,
    output logic              rate_o,
    output logic              mode_o,
    output logic              load_o,
    output logic              ack_o,
    output logic [CNT_W-1:0]  bus_rdata
);

    logic rate_q;
    logic mode_q;
    logic ctrl_wr;

    assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
    assign load_o  = bus_we && (bus_addr == A_VALUE);
    assign ack_o   = bus_we && (bus_addr == A_ACK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q <= 1'b0;
            mode_q <= 1'b0;
        end else if (ctrl_wr) begin
            rate_q <= bus_wdata[CTRL_RATE_BIT];
            mode_q <= bus_wdata[CTRL_MODE_BIT];
        end
    end

    assign rate_o = rate_q;
    assign mode_o = mode_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_VALUE: bus_rdata = count_i;
            A_CTRL: begin
                bus_rdata[CTRL_RATE_BIT] = rate_q;
                bus_rdata[CTRL_MODE_BIT] = mode_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (rate_q == $past(bus_wdata[CTRL_RATE_BIT]) &&
                     mode_q == $past(bus_wdata[CTRL_MODE_BIT]))); // R9

    AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> ($stable(rate_q) && $stable(mode_q))); // R9

endmodule

// File: rtl/cdt_core.sv
module cdt_core
    import cdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             fast_tick,
    input  logic             rate_i,
    input  logic             mode_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             uf_o
);

    localparam logic [CNT_W-1:0] CNT_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    cdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] reload_q;
    logic             tick;
    logic             at_zero;

    assign tick    = rate_i ? fast_tick : slow_tick;
    assign at_zero = (count_q == '0);

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_COUNT;
            count_q  <= CNT_ONES;
            reload_q <= CNT_ONES;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (load_i) begin
                reload_q <= load_val_i;
            end
        end
    end

    // Next-state process: LOAD, FIRST_STROBE, STEP, UNDERFLOW
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        unique case (state_q)
            ST_ARMED: begin
                if (load_i) begin
                    count_d = load_val_i;
                end else if (tick) begin
                    state_d = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (load_i) begin
                    state_d = ST_ARMED;
                    count_d = load_val_i;
                end else if (tick) begin
                    if (at_zero) begin
                        count_d = mode_i ? reload_q : CNT_ONES;
                    end else begin
                        count_d = count_q - CNT_ONE;
                    end
                end
            end
            default: begin
                state_d = ST_COUNT;
            end
        endcase
    end

    // Output process
    always_comb begin
        uf_o    = (state_q == ST_COUNT) && !load_i && tick && at_zero;
        count_o = count_q;
    end

    AST_ARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !load_i) |=> (count_q == $past(count_q))); // R2

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !load_i && tick && !at_zero)
        |=> (count_q == $past(count_q) - CNT_ONE)); // R3

    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick) |=> $stable(count_q)); // R3

    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !load_i && tick && at_zero && !mode_i)
        |=> (count_q == CNT_ONES)); // R4

    AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !load_i && tick && at_zero && mode_i)
        |=> (count_q == reload_q)); // R5

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_q == $past(load_val_i) && state_q == ST_ARMED)); // R8

endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic uf_i,
    input  logic ack_i,
    input  logic en_i,
    output logic irq_o
);

    logic status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (uf_i) begin
            status_q <= 1'b1;
        end else if (ack_i) begin
            status_q <= 1'b0;
        end
    end

    assign irq_o = status_q & en_i;

    AST_UF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        uf_i |=> status_q); // R6

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !uf_i) |=> !status_q); // R7

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!uf_i && !ack_i) |=> $stable(status_q)); // R6

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              irq_en,
    output logic              irq_o
);

    logic             rate;
    logic             mode;
    logic             load;
    logic             ack;
    logic             uf;
    logic [CNT_W-1:0] count;

    cdt_regs #(.CNT_W(CNT_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count_i   (count),
        .rate_o    (rate),
        .mode_o    (mode),
        .load_o    (load),
        .ack_o     (ack),
        .bus_rdata (bus_rdata)
    );

    cdt_core #(.CNT_W(CNT_W)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_tick  (slow_tick),
        .fast_tick  (fast_tick),
        .rate_i     (rate),
        .mode_i     (mode),
        .load_i     (load),
        .load_val_i (bus_wdata),
        .count_o    (count),
        .uf_o       (uf)
    );

    cdt_irq irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .uf_i  (uf),
        .ack_i (ack),
        .en_i  (irq_en),
        .irq_o (irq_o)
    );

endmodule

// File: tb/cdt_timer_tb_top.sv
module cdt_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        fast_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq_en = 1'b0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cdt_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .fast_tick (fast_tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_en    (irq_en),
        .irq_o     (irq_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All driving tasks start and end at a falling edge
    task automatic cycle(input logic we, input logic [1:0] a, input logic [15:0] d,
                         input logic s, input logic f);
        bus_we = we; bus_addr = a; bus_wdata = d; slow_tick = s; fast_tick = f;
        @(negedge clk);
        bus_we = 1'b0; slow_tick = 1'b0; fast_tick = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(2'd0, v); chk("R1 count", v, 16'hFFFF);
        rd(2'd1, v); chk("R1 ctrl", v, 16'h0000);
        irq_en = 1'b1; #1;
        chk("R1 irq", {15'd0, irq_o}, 16'd0);
        irq_en = 1'b0;
    endtask

    task automatic t_regmap();
        logic [15:0] v;
        cycle(1'b1, 2'd1, 16'hFFFF, 1'b0, 1'b0);
        rd(2'd1, v); chk("R9 ctrl bits", v, 16'h0003);
        rd(2'd2, v); chk("R9 addr2 reads 0", v, 16'h0000);
        rd(2'd3, v); chk("R9 addr3 reads 0", v, 16'h0000);
        cycle(1'b1, 2'd1, 16'h0000, 1'b0, 1'b0);
        rd(2'd1, v); chk("R9 ctrl cleared", v, 16'h0000);
    endtask

    task automatic t_arm_and_rate();
        logic [15:0] v;
        cycle(1'b1, 2'd0, 16'd5, 1'b0, 1'b0);
        rd(2'd0, v); chk("R2 loaded", v, 16'd5);
        cycle(1'b0, 2'd0, 16'd0, 1'b1, 1'b0);
        rd(2'd0, v); chk("R2 first strobe held", v, 16'd5);
        cycle(1'b0, 2'd0, 16'd0, 1'b1, 1'b0);
        rd(2'd0, v); chk("R2 second strobe steps", v, 16'd4);
        cycle(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);
        rd(2'd0, v); chk("R3 fast ignored on slow", v, 16'd4);
        cycle(1'b1, 2'd1, 16'h0001, 1'b0, 1'b0);
        cycle(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);
        rd(2'd0, v); chk("R3 fast steps", v, 16'd3);
        cycle(1'b0, 2'd0, 16'd0, 1'b1, 1'b0);
        rd(2'd0, v); chk("R3 slow ignored on fast", v, 16'd3);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        cycle(1'b1, 2'd0, 16'd1, 1'b0, 1'b0);
        cycle(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);
        cycle(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);
        rd(2'd0, v); chk("R3 reach zero", v, 16'd0);
        chk("R6 no irq before underflow", {15'd0, irq_o}, 16'd0);
        cycle(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);
        rd(2'd0, v); chk("R4 wrap to ones", v, 16'hFFFF);
        chk("R6 masked irq", {15'd0, irq_o}, 16'd0);
        irq_en = 1'b1; #1;
        chk("R6 latched irq shows", {15'd0, irq_o}, 16'd1);
        cycle(1'b1, 2'd2, 16'd0, 1'b0, 1'b0);
        chk("R7 ack clears", {15'd0, irq_o}, 16'd0);
    endtask

    task automatic t_reload();
        logic [15:0] v;
        cycle(1'b1, 2'd1, 16'h0003, 1'b0, 1'b0);
        cycle(1'b1, 2'd0, 16'd2, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) cycle(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);
        rd(2'd0, v); chk("R5 at zero", v, 16'd0);
        cycle(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);
        rd(2'd0, v); chk("R5 reload value", v, 16'd2);
        chk("R6 reload underflow irq", {15'd0, irq_o}, 16'd1);
        cycle(1'b1, 2'd2, 16'd0, 1'b0, 1'b0);
        chk("R7 ack clears again", {15'd0, irq_o}, 16'd0);
    endtask

    task automatic t_ack_race();
        logic [15:0] v;
        cycle(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);
        cycle(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);
        rd(2'd0, v); chk("R7 zero before race", v, 16'd0);
        cycle(1'b1, 2'd2, 16'd0, 1'b0, 1'b1);
        chk("R7 underflow beats ack", {15'd0, irq_o}, 16'd1);
        rd(2'd0, v); chk("R7 race reload", v, 16'd2);
        cycle(1'b1, 2'd2, 16'd0, 1'b0, 1'b0);
        chk("R7 later ack clears", {15'd0, irq_o}, 16'd0);
    endtask

    task automatic t_write_on_strobe();
        logic [15:0] v;
        cycle(1'b1, 2'd0, 16'd9, 1'b0, 1'b1);
        rd(2'd0, v); chk("R8 write beats strobe", v, 16'd9);
        cycle(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);
        rd(2'd0, v); chk("R8 wait restarted", v, 16'd9);
        cycle(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);
        rd(2'd0, v); chk("R8 counting resumes", v, 16'd8);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_arm_and_rate();
        t_wrap();
        t_reload();
        t_ack_race();
        t_write_on_strobe();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule